// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block runs one synchronous-shutter exposure of an image sensor for each frame trigger. A single-slope exposure has to begin with the sensor's row read pointer parked outside the pixel array. Otherwise a still-selected row takes the global reset and shows column non-uniformity. To park it, the block first writes the all-ones row address to the left and right start-row registers. It then pulses the row-start strobe together with a row clock, which selects the last line. After one blanking interval, a lone row clock shifts the pointer off the array.

Next the block writes the programmed region-of-interest start row back into the start-row registers and waits a second blanking interval. It then issues the shutter-start strobe, which is the global reset. An integration counter, clocked by the system clock, raises the timeout strobe when it reaches the programmed integration time. The shutter-stop strobe follows one cycle later, then a one-cycle frame-done pulse.

The integration time and the start row are sampled when the trigger is accepted. A trigger that arrives while a frame is in progress is dropped and sets a sticky overrun flag.

Top module: `gs_expo_seq`

## Requirements
- R1: While reset is high, and in idle after reset, every strobe output, `rowreg_wr`, `rowreg_data` and `overrun` are 0. Only reset clears `overrun`.
- R2: In the cycle after the edge that accepts a trigger (cycle 0), `rowreg_wr` is 1 and `rowreg_data` is all ones (1023 for a 10-bit row). This writes the parked row address into both start-row registers.
- R3: In cycle 1, `row_start` and `row_clk` are both 1. `row_start` is never high without `row_clk`.
- R4: The lone parking row clock comes in cycle 2+BLANK_CYC. The second pulse group therefore always follows the first by exactly BLANK_CYC+1 cycles.
- R5: In cycle 3+BLANK_CYC, `rowreg_wr` is 1 and `rowreg_data` equals the start row sampled at trigger acceptance. Changes to `roi_row` after acceptance have no effect on the frame.
- R6: `shutter_start` is high for exactly one cycle, in cycle 4+2*BLANK_CYC.
- R7: The integration counter starts from zero in the cycle after `shutter_start` and adds one per clock. `int_done` is high for one cycle, when the count equals the integration time T sampled at acceptance, i.e. in cycle 5+2*BLANK_CYC+T. Later changes to `int_time` have no effect on the frame.
- R8: An `int_time` of 0 is treated as T=1. `int_done` is never high in the cycle right after `shutter_start`.
- R9: `shutter_stop` is high one cycle after `int_done`, and `frame_done` is high the cycle after that. A trigger in the next cycle is accepted.
- R10: A trigger seen at a clock edge while the sequencer is not idle is ignored, including during the `frame_done` cycle. From the following cycle, `overrun` is 1 and stays 1. The running frame keeps its timing.
- R11: At most one of `rowreg_wr`, `row_clk`, `shutter_start`, `int_done`, `shutter_stop` and `frame_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_trig | input | 1 | Frame trigger, accepted in idle |
| int_time | input | TIME_W | Integration time in clock cycles (0 means 1) |
| roi_row | input | ROW_W | Start row of the region of interest |
| rowreg_wr | output | 1 | Write strobe for both start-row registers |
| rowreg_data | output | ROW_W | Value written to the start-row registers |
| row_start | output | 1 | Row-pointer start strobe |
| row_clk | output | 1 | Row-pointer shift clock pulse |
| shutter_start | output | 1 | Shutter start (global reset) strobe |
| shutter_stop | output | 1 | Shutter stop strobe |
| int_done | output | 1 | Integration timeout strobe |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| overrun | output | 1 | Sticky flag for a trigger dropped while busy |

## Verification
Frames are run with integration times of 0, 1, 2, 5, 37 and 200, and with start rows of 0, mid-range and high values. Each frame is compared cycle by cycle against a schedule computed from BLANK_CYC and T. Comparing the 0 and 1 cases shows the zero clamp. Comparing 1 and 2 shows where the timeout lands relative to the global reset.

Some frames change `int_time` and `roi_row` right after acceptance; these show whether the values are sampled or followed live. Other frames inject a trigger during the first blanking interval or in the frame-done cycle. These separate a dropped trigger from a restarted sequence, and one frame is triggered in the cycle right after frame-done to show that a frame can follow immediately.

// File: rtl/gs_expo_pkg.sv
package gs_expo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK_LOAD,
        ST_PARK_SEL,
        ST_BLANK_A,
        ST_PARK_SHIFT,
        ST_RESTORE,
        ST_BLANK_B,
        ST_GRESET,
        ST_INTEG,
        ST_STOP,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic park_wr;
        logic roi_wr;
        logic row_sel;
        logic row_step;
        logic greset;
        logic stop;
        logic done;
    } strobe_t;

    function automatic strobe_t decode_state(seq_state_t s);
        strobe_t o;
        o = '0;
        case (s)
            ST_PARK_LOAD:  o.park_wr = 1'b1;
            ST_PARK_SEL: begin
                o.row_sel  = 1'b1;
                o.row_step = 1'b1;
            end
            ST_PARK_SHIFT: o.row_step = 1'b1;
            ST_RESTORE:    o.roi_wr = 1'b1;
            ST_GRESET:     o.greset = 1'b1;
            ST_STOP:       o.stop = 1'b1;
            ST_DONE:       o.done = 1'b1;
            default:       o = '0;
        endcase
        return o;
    endfunction

    function automatic logic is_blank(seq_state_t s);
        return (s == ST_BLANK_A) || (s == ST_BLANK_B);
    endfunction

endpackage

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
    import gs_expo_pkg::*;
#(
    parameter int BLANK_CYC = 4,
    localparam int WAIT_W = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       int_hit,
    output seq_state_t state,
    output logic       capture,
    output logic       overrun
);

    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(BLANK_CYC - 1);

    seq_state_t        nxt;
    logic [WAIT_W-1:0] wcnt;

    assign capture = (state == ST_IDLE) && trig;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:       if (trig) nxt = ST_PARK_LOAD;
            ST_PARK_LOAD:  nxt = ST_PARK_SEL;
            ST_PARK_SEL:   nxt = ST_BLANK_A;
            ST_BLANK_A:    if (wcnt == '0) nxt = ST_PARK_SHIFT;
            ST_PARK_SHIFT: nxt = ST_RESTORE;
            ST_RESTORE:    nxt = ST_BLANK_B;
            ST_BLANK_B:    if (wcnt == '0) nxt = ST_GRESET;
            ST_GRESET:     nxt = ST_INTEG;
            ST_INTEG:      if (int_hit) nxt = ST_STOP;
            ST_STOP:       nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (is_blank(nxt) && (nxt != state)) begin
            wcnt <= WAIT_LOAD;
        end else if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (trig && (state != ST_IDLE)) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/gs_int_timer.sv
module gs_int_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [TIME_W-1:0] itime_in,
    input  logic              run,
    output logic              hit
);

    localparam logic [TIME_W-1:0] MIN_TIME = TIME_W'(1);

    logic [TIME_W-1:0] limit_q;
    logic [TIME_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= MIN_TIME;
        end else if (capture) begin
            limit_q <= (itime_in == '0) ? MIN_TIME : itime_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == limit_q);

endmodule

// File: rtl/gs_row_path.sv
module gs_row_path #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [ROW_W-1:0] roi_in,
    input  logic             park_wr,
    input  logic             roi_wr,
    output logic             rowreg_wr,
    output logic [ROW_W-1:0] rowreg_data
);

    localparam logic [ROW_W-1:0] PARK_ROW = {ROW_W{1'b1}};

    logic [ROW_W-1:0] roi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            roi_q <= '0;
        end else if (capture) begin
            roi_q <= roi_in;
        end
    end

    always_comb begin
        rowreg_wr   = park_wr || roi_wr;
        rowreg_data = '0;
        if (park_wr) begin
            rowreg_data = PARK_ROW;
        end else if (roi_wr) begin
            rowreg_data = roi_q;
        end
    end

endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq
    import gs_expo_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int TIME_W    = 16,
    parameter int BLANK_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_trig,
    input  logic [TIME_W-1:0] int_time,
    input  logic [ROW_W-1:0]  roi_row,
    output logic              rowreg_wr,
    output logic [ROW_W-1:0]  rowreg_data,
    output logic              row_start,
    output logic              row_clk,
    output logic              shutter_start,
    output logic              shutter_stop,
    output logic              int_done,
    output logic              frame_done,
    output logic              overrun
);

    seq_state_t state;
    strobe_t    stb;
    logic       capture;
    logic       hit;

    gs_seq_fsm #(
        .BLANK_CYC(BLANK_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .trig   (frame_trig),
        .int_hit(hit),
        .state  (state),
        .capture(capture),
        .overrun(overrun)
    );

    gs_int_timer #(
        .TIME_W(TIME_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .itime_in(int_time),
        .run     (state == ST_INTEG),
        .hit     (hit)
    );

    assign stb = decode_state(state);

    gs_row_path #(
        .ROW_W(ROW_W)
    ) u_row (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .roi_in     (roi_row),
        .park_wr    (stb.park_wr),
        .roi_wr     (stb.roi_wr),
        .rowreg_wr  (rowreg_wr),
        .rowreg_data(rowreg_data)
    );

    assign row_start     = stb.row_sel;
    assign row_clk       = stb.row_step;
    assign shutter_start = stb.greset;
    assign shutter_stop  = stb.stop;
    assign int_done      = hit;
    assign frame_done    = stb.done;

endmodule

// File: rtl/gs_expo_seq_chk.sv
module gs_expo_seq_chk #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             rowreg_wr,
    input logic [ROW_W-1:0] rowreg_data,
    input logic             row_start,
    input logic             row_clk,
    input logic             shutter_start,
    input logic             shutter_stop,
    input logic             int_done,
    input logic             frame_done,
    input logic             overrun
);

    assert_park_before_select_R2: assert property (@(posedge clk) disable iff (rst)
        row_start |-> ($past(rowreg_wr) && ($past(rowreg_data) == {ROW_W{1'b1}})));

    assert_select_with_clock_R3: assert property (@(posedge clk) disable iff (rst)
        row_start |-> row_clk);

    assert_no_early_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        shutter_start |=> !int_done);

    assert_stop_after_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        int_done |=> shutter_stop);

    assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
        shutter_stop |=> frame_done);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rowreg_wr, row_clk, shutter_start, int_done, shutter_stop, frame_done}));

endmodule

bind gs_expo_seq gs_expo_seq_chk #(
    .ROW_W(ROW_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rowreg_wr    (rowreg_wr),
    .rowreg_data  (rowreg_data),
    .row_start    (row_start),
    .row_clk      (row_clk),
    .shutter_start(shutter_start),
    .shutter_stop (shutter_stop),
    .int_done     (int_done),
    .frame_done   (frame_done),
    .overrun      (overrun)
);

// File: tb/gs_expo_seq_test.sv
module gs_expo_seq_test;

    localparam int ROW_W  = 10;
    localparam int TIME_W = 16;
    localparam int BLK    = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trig = 1'b0;
    logic [TIME_W-1:0] itime = '0;
    logic [ROW_W-1:0]  roi = '0;
    logic              rowreg_wr;
    logic [ROW_W-1:0]  rowreg_data;
    logic              row_start;
    logic              row_clk;
    logic              shutter_start;
    logic              shutter_stop;
    logic              int_done;
    logic              frame_done;
    logic              overrun;

    always #4 clk = ~clk;

    gs_expo_seq #(
        .ROW_W    (ROW_W),
        .TIME_W   (TIME_W),
        .BLANK_CYC(BLK)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .frame_trig   (trig),
        .int_time     (itime),
        .roi_row      (roi),
        .rowreg_wr    (rowreg_wr),
        .rowreg_data  (rowreg_data),
        .row_start    (row_start),
        .row_clk      (row_clk),
        .shutter_start(shutter_start),
        .shutter_stop (shutter_stop),
        .int_done     (int_done),
        .frame_done   (frame_done),
        .overrun      (overrun)
    );

    // itime, start row, cycle index of an injected trigger (FFFF = none), scramble inputs
    typedef struct packed {
        logic [15:0] itime;
        logic [15:0] roi;
        logic [15:0] intr_k;
        logic [15:0] scramble;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd5,   16'd100, 16'hFFFF, 16'd0},
        '{16'd0,   16'd0,   16'hFFFF, 16'd0},   // R8 zero clamp
        '{16'd1,   16'd511, 16'hFFFF, 16'd0},
        '{16'd37,  16'd300, 16'd3,    16'd1},   // R10 trigger in first blank
        '{16'd2,   16'd77,  16'd17,   16'd0},   // R10 trigger in done cycle (7+2*4+2)
        '{16'd200, 16'd639, 16'hFFFF, 16'd1}
    };

    int   n_chk = 0;
    int   n_bad = 0;
    logic ov_exp = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check_idle(input string tag);
        chk({rowreg_wr, row_start, row_clk, shutter_start, shutter_stop, int_done, frame_done} == '0,
            tag, int'({rowreg_wr, row_start, row_clk, shutter_start, shutter_stop, int_done, frame_done}), 0);
        chk(rowreg_data == '0, tag, int'(rowreg_data), 0);
    endtask

    // Called at a negedge in an idle cycle; leaves at a negedge in an idle cycle.
    task automatic run_frame(input vec_t v);
        int t;
        int last;
        t = (v.itime == 16'd0) ? 1 : int'(v.itime);
        last = 8 + 2 * BLK + t;
        itime = v.itime[TIME_W-1:0];
        roi = v.roi[ROW_W-1:0];
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int k = 0; k <= last; k++) begin
            if (v.intr_k != 16'hFFFF && k == int'(v.intr_k) + 1) ov_exp = 1'b1;
            chk(rowreg_wr == ((k == 0) || (k == 3 + BLK)), "R2 R5 rowreg_wr", int'(rowreg_wr), k);
            if (k == 0)
                chk(rowreg_data == {ROW_W{1'b1}}, "R2 park row", int'(rowreg_data), 1023);
            if (k == 3 + BLK)
                chk(rowreg_data == v.roi[ROW_W-1:0], "R5 restored row", int'(rowreg_data), int'(v.roi));
            chk(row_start == (k == 1), "R3 row_start", int'(row_start), k);
            chk(row_clk == ((k == 1) || (k == 2 + BLK)), "R3 R4 row_clk", int'(row_clk), k);
            chk(shutter_start == (k == 4 + 2 * BLK), "R6 shutter_start", int'(shutter_start), k);
            chk(int_done == (k == 5 + 2 * BLK + t), "R7 R8 int_done", int'(int_done), k);
            chk(shutter_stop == (k == 6 + 2 * BLK + t), "R9 shutter_stop", int'(shutter_stop), k);
            chk(frame_done == (k == 7 + 2 * BLK + t), "R9 frame_done", int'(frame_done), k);
            chk(overrun == ov_exp, "R10 overrun", int'(overrun), int'(ov_exp));
            chk($countones({rowreg_wr, row_clk, shutter_start, int_done, shutter_stop, frame_done}) <= 1,
                "R11 exclusive", $countones({rowreg_wr, row_clk, shutter_start, int_done, shutter_stop, frame_done}), 1);
            trig = (v.intr_k != 16'hFFFF) && (k == int'(v.intr_k));
            if (k == 0 && v.scramble != 16'd0) begin
                roi = ~roi;
                itime = itime + 16'd7;
            end
            if (k < last) @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        chk(overrun == 1'b0, "R1 overrun in reset", int'(overrun), 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after reset");
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i]);
        end
        repeat (3) @(negedge clk);
        check_idle("R9 idle after frames");
        chk(overrun == 1'b1, "R10 overrun held", int'(overrun), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ov_exp = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R1 R10 overrun cleared by reset", int'(overrun), 0);
        check_idle("R1 idle after second reset");
        run_frame('{16'd3, 16'd1023, 16'hFFFF, 16'd0});
        @(negedge clk);
        finish_up();
    end

endmodule